// File: doc/BRIEF.md
# Ordered Write-Then-Doorbell Transmit Sequencer

This block moves one software-described buffer (start address, byte count, destination ID, priority) to a remote endpoint. It cuts the buffer into write packet descriptors of at most `MAX_PAYLOAD` bytes, presents them in address order on a valid/ready descriptor port, and then presents a doorbell descriptor so the receiver learns the data is in place. Every descriptor of a transfer carries the same destination and priority, so the writes and the doorbell form one ordered flow.

A transfer runs in one of two modes, chosen per request. In confirmed mode each write asks for a response. The doorbell is held back until every response has come back with a good status. A bad status aborts the transfer, and so does a per-transfer timeout. Either way no doorbell is sent and an error pulse reports the index of the packet at fault. In posted mode no responses are expected. Completion then only means the packets have left the block, and the doorbell follows the last write at once. Posted writes use the shorter double-word-only type when the start address and the length are both multiples of 8; otherwise they use the general type.

Only one transfer is in flight at a time. `busy_o` shows this, and a request made while busy is dropped.

Top module: `wdb_tx_seq`

## Requirements
- R1: A transfer of L bytes produces ceil(L/MAX_PAYLOAD) writes. Each write is MAX_PAYLOAD bytes, except the last, which carries the remainder. Addresses rise by the size of the previous packet, and `pkt_idx_o` counts 0, 1, 2, ...
- R2: In confirmed mode every write has kind code 0 (write with response).
- R3: In confirmed mode the doorbell (kind code 3) is presented only after a good response (status 0) has been received for every write. `done_o` pulses for one cycle after the doorbell handshake.
- R4: In posted mode the doorbell follows the last write without waiting, and `done_o` pulses after its handshake. Responses that arrive while no confirmed write is outstanding have no effect.
- R5: A posted write has kind code 2 (compact, double-word-only) when `req_addr_i[2:0]` and `req_len_i[2:0]` are both zero. Otherwise it has kind code 1 (general posted write).
- R6: Every descriptor of a transfer carries the `req_dest_i` and `req_prio_i` captured at acceptance.
- R7: In confirmed mode a response with a non-zero status aborts the transfer. No doorbell is sent, `err_o` pulses, `err_idx_o` holds the 0-based index of the failing write, and `err_timeout_o` is 0.
- R8: In confirmed mode, if no doorbell has been reached TIMEOUT cycles after acceptance, `err_o` pulses with `err_timeout_o`=1 and `err_idx_o` equal to the number of responses received. No doorbell is sent.
- R9: `busy_o` is high from the cycle after a request is accepted until the cycle in which `done_o` or `err_o` pulses. A request made while busy is ignored.
- R10: A zero-length transfer produces no writes, only the doorbell.
- R11: While `pkt_valid_o` is high and `pkt_ready_i` is low, the descriptor is held unchanged in the next cycle. The only exception is an abort, which is reported by `err_o`.
- R12: After reset, `busy_o`, `pkt_valid_o`, `done_o`, `err_o`, `err_timeout_o` and `err_idx_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Transfer request strobe |
| req_addr_i | input | AW | Buffer start address |
| req_len_i | input | LW | Buffer length in bytes |
| req_dest_i | input | DW | Destination ID |
| req_prio_i | input | PW | Flow priority |
| req_confirm_i | input | 1 | 1 = confirmed mode, 0 = posted mode |
| busy_o | output | 1 | Transfer in progress |
| pkt_valid_o | output | 1 | Descriptor valid |
| pkt_ready_i | input | 1 | Descriptor accepted by the link side |
| pkt_kind_o | output | 2 | 0 write with response, 1 posted write, 2 compact write, 3 doorbell |
| pkt_addr_o | output | AW | Write address (0 for doorbell) |
| pkt_size_o | output | SZW | Write size in bytes (0 for doorbell) |
| pkt_idx_o | output | IW | Write index; number of writes on the doorbell |
| pkt_dest_o | output | DW | Destination ID |
| pkt_prio_o | output | PW | Priority |
| rsp_valid_i | input | 1 | Write response strobe, responses in write order |
| rsp_status_i | input | 2 | Response status, 0 = good |
| done_o | output | 1 | One-cycle transfer complete pulse |
| err_o | output | 1 | One-cycle transfer aborted pulse |
| err_idx_o | output | IW | Index of failing write (held until next request) |
| err_timeout_o | output | 1 | Abort caused by timeout (held until next request) |

## Verification
The bench keeps `MAX_PAYLOAD` at 256 bytes and `LW` at 16 bits. With those values, lengths of 256, 257, 300 and 1024 bytes exercise the exact-fit, one-byte-remainder, odd-remainder and four-packet splits. It also lowers `TIMEOUT` to 200 cycles. A confirmed transfer whose responses are withheld then expires within a short run, while the intentionally delayed responses in other scenarios still arrive well inside the window. Responses are paced slower than writes, so the doorbell hold in confirmed mode is actually stressed, and the link side stalls on alternate cycles in some scenarios.

// File: rtl/wdb_pkg.sv
package wdb_pkg;
  typedef enum logic [1:0] {
    PK_WR_RSP  = 2'd0,
    PK_WR_POST = 2'd1,
    PK_WR_CMP  = 2'd2,
    PK_BELL    = 2'd3
  } pkt_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_WAIT,
    ST_BELL
  } seq_state_e;

  localparam logic [1:0] RSP_OK = 2'd0;
endpackage

// File: rtl/wdb_split.sv
module wdb_split #(
  parameter int AW          = 32,
  parameter int LW          = 16,
  parameter int MAX_PAYLOAD = 256,
  parameter int SZW         = 9,
  parameter int IW          = 9
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [LW-1:0]  len_i,
  input  logic           adv_i,
  output logic [AW-1:0]  addr_o,
  output logic [SZW-1:0] size_o,
  output logic [IW-1:0]  idx_o,
  output logic           has_data_o
);
  logic [AW-1:0] addr_q;
  logic [LW-1:0] rem_q;
  logic [IW-1:0] idx_q;
  logic [SZW-1:0] size;

  always_comb begin
    if (rem_q > LW'(MAX_PAYLOAD)) size = SZW'(MAX_PAYLOAD);
    else                          size = SZW'(rem_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      rem_q  <= '0;
      idx_q  <= '0;
    end else if (load_i) begin
      addr_q <= addr_i;
      rem_q  <= len_i;
      idx_q  <= '0;
    end else if (adv_i) begin
      addr_q <= addr_q + AW'(size);
      rem_q  <= rem_q - LW'(size);
      idx_q  <= idx_q + 1'b1;
    end
  end

  assign addr_o     = addr_q;
  assign size_o     = size;
  assign idx_o      = idx_q;
  assign has_data_o = (rem_q != '0);
endmodule

// File: rtl/wdb_rsp_track.sv
module wdb_rsp_track import wdb_pkg::*; #(
  parameter int IW      = 9,
  parameter int TIMEOUT = 4096,
  localparam int TOW    = $clog2(TIMEOUT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          issue_i,
  input  logic          armed_i,
  input  logic          rsp_valid_i,
  input  logic [1:0]    rsp_status_i,
  output logic          all_acked_o,
  output logic          fail_o,
  output logic [IW-1:0] fail_idx_o,
  output logic          expired_o
);
  logic [IW:0]    out_q;
  logic [IW-1:0]  rcv_q;
  logic [TOW-1:0] tmr_q;
  logic           take;

  // responses only count while a confirmed write is outstanding
  assign take        = rsp_valid_i && armed_i && (out_q != '0);
  assign all_acked_o = (out_q == '0);
  assign fail_o      = take && (rsp_status_i != RSP_OK);
  assign fail_idx_o  = rcv_q;
  assign expired_o   = armed_i && (tmr_q >= TOW'(TIMEOUT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      rcv_q <= '0;
      tmr_q <= '0;
    end else if (clear_i) begin
      out_q <= '0;
      rcv_q <= '0;
      tmr_q <= '0;
    end else begin
      out_q <= out_q + (IW+1)'(issue_i) - (IW+1)'(take);
      if (take) rcv_q <= rcv_q + 1'b1;
      if (armed_i && !expired_o) tmr_q <= tmr_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdb_tx_seq.sv
module wdb_tx_seq import wdb_pkg::*; #(
  parameter int AW          = 32,
  parameter int LW          = 16,
  parameter int DW          = 8,
  parameter int PW          = 2,
  parameter int MAX_PAYLOAD = 256,
  parameter int TIMEOUT     = 4096,
  localparam int SZW        = $clog2(MAX_PAYLOAD + 1),
  localparam int IW         = LW - $clog2(MAX_PAYLOAD) + 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_valid_i,
  input  logic [AW-1:0]  req_addr_i,
  input  logic [LW-1:0]  req_len_i,
  input  logic [DW-1:0]  req_dest_i,
  input  logic [PW-1:0]  req_prio_i,
  input  logic           req_confirm_i,
  output logic           busy_o,
  output logic           pkt_valid_o,
  input  logic           pkt_ready_i,
  output logic [1:0]     pkt_kind_o,
  output logic [AW-1:0]  pkt_addr_o,
  output logic [SZW-1:0] pkt_size_o,
  output logic [IW-1:0]  pkt_idx_o,
  output logic [DW-1:0]  pkt_dest_o,
  output logic [PW-1:0]  pkt_prio_o,
  input  logic           rsp_valid_i,
  input  logic [1:0]     rsp_status_i,
  output logic           done_o,
  output logic           err_o,
  output logic [IW-1:0]  err_idx_o,
  output logic           err_timeout_o
);
  seq_state_e st_q, st_d;
  logic           conf_q, cmp_q;
  logic [DW-1:0]  dest_q;
  logic [PW-1:0]  prio_q;
  logic           done_q, err_q, err_to_q;
  logic [IW-1:0]  err_idx_q;

  logic           load, wr_fire, bell_fire, armed, abort;
  logic [AW-1:0]  sp_addr;
  logic [SZW-1:0] sp_size;
  logic [IW-1:0]  sp_idx;
  logic           has_data;
  logic           all_acked, trk_fail, trk_exp;
  logic [IW-1:0]  fail_idx;
  pkt_kind_e      wr_kind;

  assign load      = (st_q == ST_IDLE) && req_valid_i;
  assign wr_fire   = (st_q == ST_SEND) && has_data && pkt_ready_i;
  assign bell_fire = (st_q == ST_BELL) && pkt_ready_i;
  assign armed     = conf_q && ((st_q == ST_SEND) || (st_q == ST_WAIT));
  assign abort     = trk_fail || trk_exp;

  wdb_split #(
    .AW(AW), .LW(LW), .MAX_PAYLOAD(MAX_PAYLOAD), .SZW(SZW), .IW(IW)
  ) u_split (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .addr_i     (req_addr_i),
    .len_i      (req_len_i),
    .adv_i      (wr_fire),
    .addr_o     (sp_addr),
    .size_o     (sp_size),
    .idx_o      (sp_idx),
    .has_data_o (has_data)
  );

  wdb_rsp_track #(
    .IW(IW), .TIMEOUT(TIMEOUT)
  ) u_track (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (load),
    .issue_i      (wr_fire && conf_q),
    .armed_i      (armed),
    .rsp_valid_i  (rsp_valid_i),
    .rsp_status_i (rsp_status_i),
    .all_acked_o  (all_acked),
    .fail_o       (trk_fail),
    .fail_idx_o   (fail_idx),
    .expired_o    (trk_exp)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (req_valid_i) st_d = ST_SEND;
      ST_SEND: begin
        if (abort)          st_d = ST_IDLE;
        else if (!has_data) st_d = conf_q ? ST_WAIT : ST_BELL;
      end
      ST_WAIT: begin
        if (abort)          st_d = ST_IDLE;
        else if (all_acked) st_d = ST_BELL;
      end
      ST_BELL: if (pkt_ready_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      conf_q    <= 1'b0;
      cmp_q     <= 1'b0;
      dest_q    <= '0;
      prio_q    <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      err_idx_q <= '0;
      err_to_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= bell_fire;
      err_q  <= abort;
      if (load) begin
        conf_q    <= req_confirm_i;
        cmp_q     <= (req_addr_i[2:0] == 3'd0) && (req_len_i[2:0] == 3'd0);
        dest_q    <= req_dest_i;
        prio_q    <= req_prio_i;
        err_idx_q <= '0;
        err_to_q  <= 1'b0;
      end else if (abort) begin
        err_idx_q <= fail_idx;
        err_to_q  <= !trk_fail;
      end
    end
  end

  always_comb begin
    if (conf_q)     wr_kind = PK_WR_RSP;
    else if (cmp_q) wr_kind = PK_WR_CMP;
    else            wr_kind = PK_WR_POST;
  end

  assign busy_o        = (st_q != ST_IDLE);
  assign pkt_valid_o   = ((st_q == ST_SEND) && has_data) || (st_q == ST_BELL);
  assign pkt_kind_o    = (st_q == ST_BELL) ? PK_BELL : wr_kind;
  assign pkt_addr_o    = (st_q == ST_BELL) ? '0 : sp_addr;
  assign pkt_size_o    = (st_q == ST_BELL) ? '0 : sp_size;
  assign pkt_idx_o     = sp_idx;
  assign pkt_dest_o    = dest_q;
  assign pkt_prio_o    = prio_q;
  assign done_o        = done_q;
  assign err_o         = err_q;
  assign err_idx_o     = err_idx_q;
  assign err_timeout_o = err_to_q;
endmodule

// File: rtl/wdb_tx_seq_chk.sv
module wdb_tx_seq_chk #(
  parameter int AW          = 32,
  parameter int DW          = 8,
  parameter int PW          = 2,
  parameter int MAX_PAYLOAD = 256,
  parameter int SZW         = 9,
  parameter int IW          = 9
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           req_valid_i,
  input logic [DW-1:0]  req_dest_i,
  input logic [PW-1:0]  req_prio_i,
  input logic           busy_o,
  input logic           pkt_valid_o,
  input logic           pkt_ready_i,
  input logic [1:0]     pkt_kind_o,
  input logic [AW-1:0]  pkt_addr_o,
  input logic [SZW-1:0] pkt_size_o,
  input logic [IW-1:0]  pkt_idx_o,
  input logic [DW-1:0]  pkt_dest_o,
  input logic [PW-1:0]  pkt_prio_o,
  input logic           rsp_valid_i,
  input logic           done_o,
  input logic           err_o
);
  logic          accept;
  logic [IW:0]   pend_q;
  logic [DW-1:0] dest_l;
  logic [PW-1:0] prio_l;

  assign accept = req_valid_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      dest_l <= '0;
      prio_l <= '0;
    end else if (accept) begin
      pend_q <= '0;
      dest_l <= req_dest_i;
      prio_l <= req_prio_i;
    end else begin
      pend_q <= pend_q
              + (IW+1)'(pkt_valid_o && pkt_ready_i && (pkt_kind_o == 2'd0))
              - (IW+1)'(rsp_valid_i && busy_o && (pend_q != '0));
    end
  end

  assert_bell_after_acks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_o && pkt_kind_o == 2'd3) |-> (pend_q == '0));

  assert_size_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_o && pkt_kind_o != 2'd3) |-> (pkt_size_o != '0 && pkt_size_o <= SZW'(MAX_PAYLOAD)));

  assert_compact_aligned_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_o && pkt_kind_o == 2'd2) |-> (pkt_addr_o[2:0] == 3'd0 && pkt_size_o[2:0] == 3'd0));

  assert_flow_ids_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o |-> (pkt_dest_o == dest_l && pkt_prio_o == prio_l));

  assert_valid_in_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o |-> busy_o);

  assert_idle_on_end_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |-> !busy_o);

  assert_single_outcome_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));

  assert_hold_stable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_o && !pkt_ready_i) |=>
      ((pkt_valid_o && $stable(pkt_kind_o) && $stable(pkt_addr_o) &&
        $stable(pkt_size_o) && $stable(pkt_idx_o)) || err_o));
endmodule

bind wdb_tx_seq wdb_tx_seq_chk #(
  .AW(AW), .DW(DW), .PW(PW), .MAX_PAYLOAD(MAX_PAYLOAD), .SZW(SZW), .IW(IW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_dest_i  (req_dest_i),
  .req_prio_i  (req_prio_i),
  .busy_o      (busy_o),
  .pkt_valid_o (pkt_valid_o),
  .pkt_ready_i (pkt_ready_i),
  .pkt_kind_o  (pkt_kind_o),
  .pkt_addr_o  (pkt_addr_o),
  .pkt_size_o  (pkt_size_o),
  .pkt_idx_o   (pkt_idx_o),
  .pkt_dest_o  (pkt_dest_o),
  .pkt_prio_o  (pkt_prio_o),
  .rsp_valid_i (rsp_valid_i),
  .done_o      (done_o),
  .err_o       (err_o)
);

// File: tb/sim_wdb_tx_seq.sv
`timescale 1ns/1ps
module sim_wdb_tx_seq;
  localparam int TMO = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [15:0] req_len = '0;
  logic [7:0]  req_dest = '0;
  logic [1:0]  req_prio = '0;
  logic        req_conf = 1'b0;
  logic        busy, pkt_valid, done, err, err_to;
  logic        pkt_ready = 1'b1;
  logic [1:0]  pkt_kind;
  logic [31:0] pkt_addr;
  logic [8:0]  pkt_size, pkt_idx, err_idx;
  logic [7:0]  pkt_dest;
  logic [1:0]  pkt_prio;
  logic        rsp_valid = 1'b0;
  logic [1:0]  rsp_status = '0;

  int nchk = 0, nerr = 0;
  int cyc = 0;
  int npk = 0, wr_seen = 0, rsp_sent = 0, bell_snap = 0;
  int fail_at = -1;
  bit ready_alt = 0, rsp_en = 0, spur = 0;
  logic [1:0]  m_kind [0:255];
  logic [31:0] m_addr [0:255];
  logic [8:0]  m_size [0:255];
  logic [8:0]  m_idx  [0:255];
  logic [7:0]  m_dest [0:255];
  logic [1:0]  m_prio [0:255];

  always #2.5 clk = ~clk;

  wdb_tx_seq #(.TIMEOUT(TMO)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_len_i(req_len),
    .req_dest_i(req_dest), .req_prio_i(req_prio), .req_confirm_i(req_conf),
    .busy_o(busy), .pkt_valid_o(pkt_valid), .pkt_ready_i(pkt_ready),
    .pkt_kind_o(pkt_kind), .pkt_addr_o(pkt_addr), .pkt_size_o(pkt_size),
    .pkt_idx_o(pkt_idx), .pkt_dest_o(pkt_dest), .pkt_prio_o(pkt_prio),
    .rsp_valid_i(rsp_valid), .rsp_status_i(rsp_status),
    .done_o(done), .err_o(err), .err_idx_o(err_idx), .err_timeout_o(err_to)
  );

  // link side and responder, driven just after each edge
  always @(posedge clk) begin
    #1;
    cyc = cyc + 1;
    pkt_ready = ready_alt ? cyc[0] : 1'b1;
    rsp_valid = 1'b0;
    rsp_status = 2'd0;
    if (rsp_en && (wr_seen - rsp_sent) > 0 && (cyc % 4) == 0) begin
      rsp_valid = 1'b1;
      rsp_status = (rsp_sent == fail_at) ? 2'd2 : 2'd0;
      rsp_sent = rsp_sent + 1;
    end else if (spur && (cyc % 3) == 0) begin
      rsp_valid = 1'b1;
      rsp_status = 2'd1;
    end
  end

  // handshake monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n && pkt_valid && pkt_ready) begin
      m_kind[npk & 255] = pkt_kind;
      m_addr[npk & 255] = pkt_addr;
      m_size[npk & 255] = pkt_size;
      m_idx[npk & 255]  = pkt_idx;
      m_dest[npk & 255] = pkt_dest;
      m_prio[npk & 255] = pkt_prio;
      if (pkt_kind == 2'd0) wr_seen = wr_seen + 1;
      if (pkt_kind == 2'd3) bell_snap = rsp_sent;
      npk = npk + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic start(input logic [31:0] a, input int len, input logic [7:0] d,
                       input logic [1:0] p, input bit conf);
    @(posedge clk); #1;
    req_addr = a; req_len = 16'(len); req_dest = d; req_prio = p; req_conf = conf;
    req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_end(output bit gd, output bit ge, output int n);
    gd = 0; ge = 0; n = 0;
    while (n < 3000 && !gd && !ge) begin
      @(negedge clk);
      n++;
      if (done) gd = 1;
      if (err) ge = 1;
    end
  endtask

  task automatic settle();
    repeat (40) @(posedge clk);
  endtask

  // compare the recorded writes and doorbell of one transfer
  task automatic chk_stream(input int b, input logic [31:0] a, input int len, input logic [1:0] k,
                            input logic [7:0] d, input logic [1:0] p, input string tag);
    int nw = (len + 255) / 256;
    chk(npk - b == nw + 1, {tag, " R1 packet count"}, npk - b, nw + 1);
    for (int i = 0; i < nw; i++) begin
      int sz = (len - i*256 > 256) ? 256 : len - i*256;
      chk(m_addr[b+i] == a + 32'(i*256), {tag, " R1 addr"}, m_addr[b+i], a + 32'(i*256));
      chk(m_size[b+i] == 9'(sz), {tag, " R1 size"}, m_size[b+i], sz);
      chk(m_idx[b+i] == 9'(i), {tag, " R1 idx"}, m_idx[b+i], i);
      chk(m_kind[b+i] == k, {tag, " R2/R5 kind"}, m_kind[b+i], k);
      chk(m_dest[b+i] == d && m_prio[b+i] == p, {tag, " R6 dest/prio"}, m_dest[b+i], d);
    end
    chk(m_kind[b+nw] == 2'd3, {tag, " R3/R4 doorbell last"}, m_kind[b+nw], 3);
    chk(m_dest[b+nw] == d && m_prio[b+nw] == p, {tag, " R6 doorbell ids"}, m_dest[b+nw], d);
  endtask

  task automatic t_reset();
    chk(busy == 0 && pkt_valid == 0, "R12 busy/valid after reset", {busy, pkt_valid}, 0);
    chk(done == 0 && err == 0, "R12 done/err after reset", {done, err}, 0);
    chk(err_idx == 0 && err_to == 0, "R12 err info after reset", err_idx, 0);
  endtask

  task automatic t_confirmed_1024();
    bit gd, ge; int n; int b = npk; int rb = rsp_sent;
    ready_alt = 1; rsp_en = 1;
    start(32'h1000, 1024, 8'd5, 2'd2, 1'b1);
    chk(busy == 1, "R9 busy after accept", busy, 1);
    wait_end(gd, ge, n);
    chk(gd && !ge, "R3 confirmed done", {gd, ge}, 2);
    chk_stream(b, 32'h1000, 1024, 2'd0, 8'd5, 2'd2, "t1");
    chk(bell_snap - rb == 4, "R3 all responses before doorbell", bell_snap - rb, 4);
    chk(busy == 0, "R9 idle after done", busy, 0);
    ready_alt = 0; settle();
  endtask

  task automatic t_posted_aligned();
    bit gd, ge; int n; int b = npk;
    rsp_en = 0; spur = 1;
    start(32'h2000, 512, 8'd9, 2'd1, 1'b0);
    wait_end(gd, ge, n);
    chk(gd && !ge, "R4 posted done despite stray responses", {gd, ge}, 2);
    chk_stream(b, 32'h2000, 512, 2'd2, 8'd9, 2'd1, "t2 R5 compact");
    chk(n < 12, "R4 doorbell without waiting", n, 12);
    spur = 0; settle();
  endtask

  task automatic t_posted_unaligned();
    bit gd, ge; int n; int b = npk;
    ready_alt = 1;
    start(32'h3003, 300, 8'd1, 2'd3, 1'b0);
    wait_end(gd, ge, n);
    chk(gd && !ge, "R4 posted unaligned done", {gd, ge}, 2);
    chk_stream(b, 32'h3003, 300, 2'd1, 8'd1, 2'd3, "t3 R5 general");
    ready_alt = 0; settle();
  endtask

  task automatic t_boundaries();
    bit gd, ge; int n; int b;
    rsp_en = 1;
    b = npk;
    start(32'h4000, 256, 8'd2, 2'd0, 1'b1);
    wait_end(gd, ge, n);
    chk(gd, "R1 exact 256 done", gd, 1);
    chk_stream(b, 32'h4000, 256, 2'd0, 8'd2, 2'd0, "t4a");
    settle();
    b = npk;
    start(32'h4800, 257, 8'd2, 2'd0, 1'b1);
    wait_end(gd, ge, n);
    chk(gd, "R1 257 done", gd, 1);
    chk_stream(b, 32'h4800, 257, 2'd0, 8'd2, 2'd0, "t4b");
    settle();
  endtask

  task automatic t_zero_len();
    bit gd, ge; int n; int b = npk;
    start(32'h4C00, 0, 8'd3, 2'd1, 1'b1);
    wait_end(gd, ge, n);
    chk(gd && !ge, "R10 zero length done", {gd, ge}, 2);
    chk(npk - b == 1 && m_kind[b] == 2'd3, "R10 doorbell only", npk - b, 1);
    settle();
  endtask

  task automatic t_error_rsp();
    bit gd, ge; int n; int b = npk;
    rsp_en = 1; fail_at = rsp_sent + 2;
    start(32'h6000, 1024, 8'd7, 2'd1, 1'b1);
    wait_end(gd, ge, n);
    chk(ge && !gd, "R7 error aborts", {gd, ge}, 1);
    chk(err_idx == 9'd2, "R7 failing index", err_idx, 2);
    chk(err_to == 0, "R7 not a timeout", err_to, 0);
    settle();
    for (int i = b; i < npk; i++)
      chk(m_kind[i] != 2'd3, "R7 no doorbell after error", m_kind[i], 0);
    fail_at = -1;
  endtask

  task automatic t_busy_refuse();
    bit gd, ge; int n; int b = npk;
    rsp_en = 0;
    start(32'h5000, 1024, 8'd4, 2'd0, 1'b1);
    repeat (6) @(posedge clk);
    start(32'h9000, 64, 8'd8, 2'd3, 1'b0);
    repeat (20) @(negedge clk);
    chk(busy == 1, "R9 still busy waiting for responses", busy, 1);
    rsp_en = 1;
    wait_end(gd, ge, n);
    chk(gd && !ge, "R9 first transfer completes", {gd, ge}, 2);
    chk_stream(b, 32'h5000, 1024, 2'd0, 8'd4, 2'd0, "t7 R9 refused request left no trace");
    settle();
    chk(npk - b == 5 && busy == 0, "R9 refused request never started", npk - b, 5);
  endtask

  task automatic t_timeout();
    bit gd, ge; int n; int b = npk;
    rsp_en = 0;
    start(32'h7000, 512, 8'd6, 2'd2, 1'b1);
    wait_end(gd, ge, n);
    chk(ge && !gd, "R8 timeout aborts", {gd, ge}, 1);
    chk(err_to == 1, "R8 timeout flag", err_to, 1);
    chk(err_idx == 0, "R8 index = responses received", err_idx, 0);
    chk(n >= TMO - 5 && n <= TMO + 5, "R8 expiry window", n, TMO);
    for (int i = b; i < npk; i++)
      chk(m_kind[i] != 2'd3, "R8 no doorbell after timeout", m_kind[i], 0);
    rsp_en = 1; settle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired (all requirements)");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    t_reset();
    t_confirmed_1024();
    t_posted_aligned();
    t_posted_unaligned();
    t_boundaries();
    t_zero_len();
    t_error_rsp();
    t_busy_refuse();
    t_timeout();
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule